// File: doc/BRIEF.md
# DDR2 Clock-Enable Power-State Sequencer

This block sits between a DDR2 memory controller's scheduler and the command pins. It owns the clock-enable (CKE) level and supplies the command the scheduler should place on the chip-select, row-strobe, column-strobe and write-enable pins whenever the memory is entering, leaving or resting in a low-power mode. The scheduler asks for power-down or self refresh with one-cycle strobes. It also reports whether any bank is open and whether a read, write, mode-register load or precharge is still in flight. The sequencer then chooses the power mode, holds each CKE level for a minimum number of cycles, and guards the recovery windows after an exit. Two outputs tell the scheduler when it may issue commands again and, separately, when it may issue reads.

The state machine has six states. NOT_INIT (reset, CKE low) moves to NORMAL when `init_done` is seen and the low level has been held long enough. NORMAL (CKE high) moves on an accepted request. It goes to ACT_PD if a bank is open and to PRE_PD if all banks are idle, or to SELF_REF for a self-refresh request. ACT_PD and PRE_PD return to NORMAL on wake, on a pending refresh, or when the power-down time cap runs out. SELF_REF moves to SR_EXIT on wake. SR_EXIT (CKE high, recovery) returns to NORMAL once the read recovery window has elapsed. A request that arrives before the current CKE level has been held long enough is armed. It is taken as soon as the minimum time is met and no operation is in flight.

Top module: `cke_power_seq`

## Requirements
- R1: After reset `cke` is 0, `pwr_state` reads 0 (not initialized), and `cmd_allowed` and `read_allowed` are 0. A pulse on `init_done`, once CKE has been low for at least MIN_CKE cycles, moves `pwr_state` to 1 (normal) with `cke` high on the next cycle.
- R2: A power-down entry with `bank_open`=1 gives `pwr_state` 2 (active power-down). With `bank_open`=0 it gives `pwr_state` 3 (precharge power-down). In both cases `cke` is 0 from the first cycle of the mode.
- R3: Each CKE level lasts at least MIN_CKE cycles. A request strobed in cycle i of a high level (cycle 1 being the first high cycle) takes effect at the end of cycle max(i, MIN_CKE). A wake request first present in cycle j of a low level ends that level at the end of cycle max(j, MIN_CKE).
- R4: `cmd_allowed` and `read_allowed` are 0 in the first cycle of normal operation after CKE rises, and from the cycle after an accepted but not yet taken request until the entry.
- R5: A request strobed while `busy`=1 is refused: `illegal_req` pulses and the state is unchanged. An armed request is not taken in any cycle where `busy`=1.
- R6: On self-refresh entry, `cmd` equals 4'b0001 ({cs_n,ras_n,cas_n,we_n} = REFRESH) during exactly the first cycle of `pwr_state` 4 (self refresh). Otherwise `cmd` is 4'b0111 (NOP).
- R7: A self-refresh request with `bank_open`=1 at the strobe, or at the cycle where an armed self-refresh request would be taken, is refused with an `illegal_req` pulse. The sequencer stays in normal and the request is discarded.
- R8: From either power-down state, `wake_req` returns `pwr_state` to 1 with `cke` high, subject to R3.
- R9: A wake in self refresh moves to `pwr_state` 5 (self-refresh exit) with `cke` high. Counting the first such cycle as 0, `cmd_allowed` is 1 only in cycles numbered above TXSNR_CYC, and `read_allowed` stays 0. The state returns to 1 at the end of cycle TXSRD_CYC, where `read_allowed` becomes 1.
- R10: `refresh_pending` forces a power-down exit at the end of the minimum CKE-low time. It has no effect in self refresh.
- R11: Without wake or refresh, a power-down state lasts exactly PD_MAX_CYC cycles.
- R12: A request strobed in any state other than normal pulses `illegal_req` and changes nothing.
- R13: `illegal_req` is 1 only in the cycle after the refused strobe or the refused entry, and 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Pulse: memory initialization finished |
| pd_req | input | 1 | Strobe: request power-down |
| sr_req | input | 1 | Strobe: request self refresh |
| bank_open | input | 1 | At least one bank is open |
| busy | input | 1 | Read, write, mode-register load or precharge in progress |
| refresh_pending | input | 1 | A refresh is due |
| wake_req | input | 1 | Level: leave the current low-power mode |
| cke | output | 1 | Clock-enable level for the memory |
| cmd | output | 4 | {cs_n,ras_n,cas_n,we_n} to drive while the block owns the bus |
| pwr_state | output | 3 | Current power state code |
| cmd_allowed | output | 1 | Scheduler may issue non-NOP commands |
| read_allowed | output | 1 | Scheduler may issue reads |
| illegal_req | output | 1 | One-cycle pulse: request refused |

## Verification
The hardest paths to reach are the ones where an armed request meets a changed condition. A self-refresh request can be armed while all banks are idle and then see a bank open before entry. A power-down request can be armed and then see a busy window before entry. Both paths need a strobe that arrives while the CKE-high level is still too young to move. The bench gets there by strobing in the first cycle after a power-down exit and then changing `bank_open` or `busy` within the next MIN_CKE-1 cycles. It sweeps the strobe cycle and the wake cycle across the dwell boundary, and computes each entry and exit cycle as a maximum against MIN_CKE.

// File: rtl/cke_seq_pkg.sv
package cke_seq_pkg;

    typedef enum logic [2:0] {
        PS_NOT_INIT = 3'd0,
        PS_NORMAL   = 3'd1,
        PS_ACT_PD   = 3'd2,
        PS_PRE_PD   = 3'd3,
        PS_SELF_REF = 3'd4,
        PS_SR_EXIT  = 3'd5
    } pwr_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP     = 4'b0111;
    localparam logic [3:0] CMD_REFRESH = 4'b0001;

    function automatic logic cke_level(input pwr_state_e s);
        return (s == PS_NORMAL) || (s == PS_SR_EXIT);
    endfunction

endpackage

// File: rtl/cke_dwell_timer.sv
// Counts cycles the CKE level has been held; restarts on every level flip.
module cke_dwell_timer #(
    parameter int MIN_CKE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_flip,
    output logic dwell_met,
    output logic first_cycle
);
    localparam int W = $clog2(MIN_CKE + 1);
    localparam logic [W-1:0] CAP = W'(MIN_CKE);

    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= W'(1);
        end else if (level_flip) begin
            held_q <= W'(1);
        end else if (held_q < CAP) begin
            held_q <= held_q + W'(1);
        end
    end

    assign dwell_met   = (held_q >= CAP);
    assign first_cycle = (held_q == W'(1));

endmodule

// File: rtl/pwr_sat_counter.sv
// Up-counter from zero that stops at LIMIT; cleared while clear is high.
module pwr_sat_counter #(
    parameter int LIMIT = 8,
    parameter int W     = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (count != TOP) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/cke_power_seq.sv
module cke_power_seq
    import cke_seq_pkg::*;
#(
    parameter int MIN_CKE    = 3,
    parameter int TXSNR_CYC  = 128,
    parameter int TXSRD_CYC  = 200,
    parameter int PD_MAX_CYC = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_done,
    input  logic       pd_req,
    input  logic       sr_req,
    input  logic       bank_open,
    input  logic       busy,
    input  logic       refresh_pending,
    input  logic       wake_req,
    output logic       cke,
    output logic [3:0] cmd,
    output logic [2:0] pwr_state,
    output logic       cmd_allowed,
    output logic       read_allowed,
    output logic       illegal_req
);
    localparam int SRX_W = $clog2(TXSRD_CYC + 1);
    localparam int PD_LIMIT = PD_MAX_CYC - 1;
    localparam int PD_W  = $clog2(PD_LIMIT + 1);
    localparam logic [SRX_W-1:0] SRX_END  = SRX_W'(TXSRD_CYC);
    localparam logic [SRX_W-1:0] SRX_MARK = SRX_W'(TXSNR_CYC);
    localparam logic [PD_W-1:0]  PD_END   = PD_W'(PD_LIMIT);

    pwr_state_e st_q, st_d;
    logic pend_pd_q, pend_pd_d;
    logic pend_sr_q, pend_sr_d;
    logic illegal_q, illegal_d;
    logic dwell_met, first_cycle, level_flip;
    logic req_any, strobe_bad, want_sr, want_pd;
    logic in_pd, pd_cap, srx_done, norm_open;
    logic [SRX_W-1:0] srx_cnt;
    logic [PD_W-1:0]  pd_cnt;

    // ---------------- timers ----------------
    cke_dwell_timer #(.MIN_CKE(MIN_CKE)) u_dwell (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_flip (level_flip),
        .dwell_met  (dwell_met),
        .first_cycle(first_cycle)
    );

    pwr_sat_counter #(.LIMIT(TXSRD_CYC), .W(SRX_W)) u_srx_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(st_q != PS_SR_EXIT),
        .count(srx_cnt)
    );

    assign in_pd = (st_q == PS_ACT_PD) || (st_q == PS_PRE_PD);

    pwr_sat_counter #(.LIMIT(PD_LIMIT), .W(PD_W)) u_pd_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(!in_pd),
        .count(pd_cnt)
    );

    assign pd_cap   = (pd_cnt == PD_END);
    assign srx_done = (srx_cnt == SRX_END);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= PS_NOT_INIT;
            pend_pd_q <= 1'b0;
            pend_sr_q <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            pend_pd_q <= pend_pd_d;
            pend_sr_q <= pend_sr_d;
            illegal_q <= illegal_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d       = st_q;
        pend_pd_d  = 1'b0;
        pend_sr_d  = 1'b0;
        illegal_d  = 1'b0;
        req_any    = pd_req || sr_req;
        strobe_bad = 1'b0;
        want_sr    = 1'b0;
        want_pd    = 1'b0;
        unique case (st_q)
            PS_NOT_INIT: begin
                illegal_d = req_any;
                if (init_done && dwell_met) begin
                    st_d = PS_NORMAL;
                end
            end
            PS_NORMAL: begin
                strobe_bad = req_any && (busy || (sr_req && bank_open));
                illegal_d  = strobe_bad;
                want_sr    = pend_sr_q || (sr_req && !strobe_bad);
                want_pd    = !want_sr && (pend_pd_q || (pd_req && !strobe_bad));
                pend_sr_d  = want_sr;
                pend_pd_d  = want_pd;
                if ((want_sr || want_pd) && dwell_met && !busy) begin
                    pend_sr_d = 1'b0;
                    pend_pd_d = 1'b0;
                    if (want_sr) begin
                        if (bank_open) begin
                            illegal_d = 1'b1;
                        end else begin
                            st_d = PS_SELF_REF;
                        end
                    end else begin
                        st_d = bank_open ? PS_ACT_PD : PS_PRE_PD;
                    end
                end
            end
            PS_ACT_PD, PS_PRE_PD: begin
                illegal_d = req_any;
                if (dwell_met && (wake_req || refresh_pending || pd_cap)) begin
                    st_d = PS_NORMAL;
                end
            end
            PS_SELF_REF: begin
                illegal_d = req_any;
                if (dwell_met && wake_req) begin
                    st_d = PS_SR_EXIT;
                end
            end
            PS_SR_EXIT: begin
                illegal_d = req_any;
                if (srx_done) begin
                    st_d = PS_NORMAL;
                end
            end
            default: st_d = PS_NOT_INIT;
        endcase
    end

    assign level_flip = cke_level(st_d) != cke_level(st_q);

    // ---------------- outputs ----------------
    always_comb begin
        norm_open    = (st_q == PS_NORMAL) && !first_cycle && !pend_pd_q && !pend_sr_q;
        cke          = cke_level(st_q);
        cmd          = (st_q == PS_SELF_REF && first_cycle) ? CMD_REFRESH : CMD_NOP;
        pwr_state    = st_q;
        read_allowed = norm_open;
        cmd_allowed  = norm_open || ((st_q == PS_SR_EXIT) && (srx_cnt > SRX_MARK));
        illegal_req  = illegal_q;
    end

endmodule

// File: rtl/cke_power_seq_chk.sv
module cke_power_seq_chk #(
    parameter int MIN_CKE = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_req,
    input logic       sr_req,
    input logic       bank_open,
    input logic       busy,
    input logic       cke,
    input logic [3:0] cmd,
    input logic [2:0] pwr_state,
    input logic       cmd_allowed,
    input logic       read_allowed,
    input logic       illegal_req
);
    localparam int W = $clog2(MIN_CKE + 1);

    logic         lvl_q;
    logic [W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= W'(1);
        end else begin
            lvl_q <= cke;
            if (cke != lvl_q) begin
                run_q <= W'(1);
            end else if (run_q < W'(MIN_CKE)) begin
                run_q <= run_q + W'(1);
            end
        end
    end

    p_cke_dwell_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cke != lvl_q) |-> (run_q >= W'(MIN_CKE)));

    p_refresh_in_sref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0001) |-> (!cke && pwr_state == 3'd4));

    p_refresh_at_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd4 && $past(pwr_state) != 3'd4) |-> (cmd == 4'b0001));

    p_sref_banks_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd4 && $past(pwr_state) != 3'd4) |-> !$past(bank_open));

    p_act_pd_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd2 && $past(pwr_state) != 3'd2) |-> $past(bank_open));

    p_pre_pd_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd3 && $past(pwr_state) != 3'd3) |-> !$past(bank_open));

    p_no_entry_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> !$past(busy));

    p_read_in_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        read_allowed |-> (pwr_state == 3'd1));

    p_cmd_needs_cke_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_allowed |-> cke);

    p_illegal_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_req |-> $past(pd_req || sr_req || bank_open));

endmodule

bind cke_power_seq cke_power_seq_chk #(.MIN_CKE(MIN_CKE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_req      (pd_req),
    .sr_req      (sr_req),
    .bank_open   (bank_open),
    .busy        (busy),
    .cke         (cke),
    .cmd         (cmd),
    .pwr_state   (pwr_state),
    .cmd_allowed (cmd_allowed),
    .read_allowed(read_allowed),
    .illegal_req (illegal_req)
);

// File: tb/tb_cke_power_seq.sv
module tb_cke_power_seq;
    localparam int MINC   = 3;
    localparam int TXSNR  = 5;
    localparam int TXSRD  = 9;
    localparam int PDMAX  = 20;

    logic clk = 1'b0;
    logic rst_n, init_done, pd_req, sr_req, bank_open, busy, refresh_pending, wake_req;
    logic cke, cmd_allowed, read_allowed, illegal_req;
    logic [3:0] cmd;
    logic [2:0] pwr_state;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cke_power_seq #(
        .MIN_CKE(MINC), .TXSNR_CYC(TXSNR), .TXSRD_CYC(TXSRD), .PD_MAX_CYC(PDMAX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .pd_req(pd_req),
        .sr_req(sr_req), .bank_open(bank_open), .busy(busy),
        .refresh_pending(refresh_pending), .wake_req(wake_req),
        .cke(cke), .cmd(cmd), .pwr_state(pwr_state), .cmd_allowed(cmd_allowed),
        .read_allowed(read_allowed), .illegal_req(illegal_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Starts in the first cycle of a low level; leaves in the first normal cycle.
    task automatic leave_pd();
        wake_req = 1'b1;
        repeat (MINC) tick();
        wake_req = 1'b0;
    endtask

    // Starts in the first normal cycle after CKE rose.
    task automatic pd_round(input int i, input logic bank, input int j);
        int hi = (i > MINC) ? i : MINC;
        int lo = (j > MINC) ? j : MINC;
        for (int c = 1; c <= hi; c++) begin
            chk("R3 cke high before entry", cke, 1);
            chk("R4 cmd_allowed around armed request", cmd_allowed, (c > 1 && c <= i));
            bank_open = bank;
            pd_req = (c == i);
            tick();
            pd_req = 1'b0;
        end
        chk("R2 power-down mode", pwr_state, bank ? 3'd2 : 3'd3);
        chk("R2 cke low in power-down", cke, 0);
        for (int l = 1; l <= lo; l++) begin
            chk("R3 cke low before exit", cke, 0);
            wake_req = (l >= j);
            tick();
        end
        wake_req = 1'b0;
        chk("R8 back to normal", pwr_state, 3'd1);
        chk("R8 cke high after wake", cke, 1);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        rst_n = 0; init_done = 0; pd_req = 0; sr_req = 0; bank_open = 0;
        busy = 0; refresh_pending = 0; wake_req = 0;
        repeat (3) tick();
        rst_n = 1;
        chk("R1 reset cke", cke, 0);
        chk("R1 reset state", pwr_state, 3'd0);
        chk("R1 reset cmd_allowed", cmd_allowed, 0);
        chk("R1 reset read_allowed", read_allowed, 0);

        // R12: request before initialization
        pd_req = 1; tick(); pd_req = 0;
        chk("R12 illegal before init", illegal_req, 1);
        chk("R12 state unchanged", pwr_state, 3'd0);
        tick();
        chk("R13 illegal one cycle", illegal_req, 0);
        repeat (3) tick();
        init_done = 1; tick(); init_done = 0;
        chk("R1 normal after init", pwr_state, 3'd1);
        chk("R1 cke high after init", cke, 1);

        // R3/R2/R8/R4 sweep
        for (int i = 1; i <= 5; i++)
            for (int b = 0; b <= 1; b++)
                for (int j = 1; j <= 5; j += 3)
                    pd_round(i, b[0], j);

        // R5: armed request held off by busy
        bank_open = 0;
        pd_req = 1; tick(); pd_req = 0;
        busy = 1;
        for (int c = 2; c <= 5; c++) begin
            chk("R5 no entry while busy", cke, 1);
            chk("R4 cmd blocked while armed", cmd_allowed, 0);
            tick();
        end
        busy = 0; tick();
        chk("R5 entry after busy drops", pwr_state, 3'd3);
        leave_pd();

        // R5: strobe while busy refused
        busy = 1; pd_req = 1; tick(); pd_req = 0; busy = 0;
        chk("R5 illegal when busy", illegal_req, 1);
        repeat (4) tick();
        chk("R5 refused request ignored", pwr_state, 3'd1);
        chk("R5 cke stays high", cke, 1);

        // R7: self refresh with bank open refused
        bank_open = 1; sr_req = 1; tick(); sr_req = 0;
        chk("R7 illegal sr with bank open", illegal_req, 1);
        tick();
        chk("R13 illegal cleared", illegal_req, 0);
        chk("R7 stays normal", pwr_state, 3'd1);
        bank_open = 0;

        // R6/R10/R12/R9: self refresh round
        sr_req = 1; tick(); sr_req = 0;
        chk("R6 self refresh state", pwr_state, 3'd4);
        chk("R6 cke low", cke, 0);
        chk("R6 refresh command on entry", cmd, 4'b0001);
        refresh_pending = 1;
        tick();
        chk("R6 nop after entry", cmd, 4'b0111);
        repeat (25) tick();
        chk("R10 refresh_pending ignored in self refresh", pwr_state, 3'd4);
        refresh_pending = 0;
        pd_req = 1; tick(); pd_req = 0;
        chk("R12 illegal in self refresh", illegal_req, 1);
        chk("R12 self refresh kept", pwr_state, 3'd4);
        wake_req = 1; tick(); wake_req = 0;
        chk("R9 exit state", pwr_state, 3'd5);
        chk("R9 cke high", cke, 1);
        for (int r = 0; r <= TXSRD; r++) begin
            chk("R9 still in exit window", pwr_state, 3'd5);
            chk("R9 cmd_allowed vs tXSNR", cmd_allowed, (r > TXSNR));
            chk("R9 reads blocked", read_allowed, 0);
            tick();
        end
        chk("R9 normal after tXSRD", pwr_state, 3'd1);
        chk("R9 reads allowed", read_allowed, 1);
        chk("R9 commands allowed", cmd_allowed, 1);

        // R10: refresh forces power-down exit
        pd_req = 1; tick(); pd_req = 0;
        refresh_pending = 1;
        for (int l = 1; l <= MINC; l++) begin
            chk("R10 low until minimum", cke, 0);
            tick();
        end
        refresh_pending = 0;
        chk("R10 forced exit", pwr_state, 3'd1);

        // R7: armed self refresh dropped when a bank opens
        sr_req = 1; tick(); sr_req = 0;
        bank_open = 1; tick(); tick();
        chk("R7 armed sr dropped", illegal_req, 1);
        chk("R7 still normal", pwr_state, 3'd1);
        chk("R7 cke high", cke, 1);
        chk("R4 commands reopened", cmd_allowed, 1);
        bank_open = 0;

        // R11: power-down time cap
        pd_req = 1; tick(); pd_req = 0;
        for (int l = 1; l <= PDMAX; l++) begin
            chk("R11 low within cap", pwr_state, 3'd3);
            tick();
        end
        chk("R11 exit at cap", pwr_state, 3'd1);
        chk("R11 cke high at cap", cke, 1);

        report();
        $finish;
    end

endmodule